// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block watches the ignition key and the seat-belt latch and sounds a reminder. The key and belt arrive as single-cycle event pulses. A seconds timer inside the block counts one-second enables on `tick_i`. It is restarted when the key is turned on, and it marks the 5 s and 10 s points after that restart.

The controller has three states: idle, waiting and alarming. A key-on event while idle starts the timer and enters waiting. If the belt is fastened or the key is turned off before the 5 s mark, the controller goes back to idle with no alarm. Otherwise it raises the alarm. The alarm ends at the 10 s mark, or earlier if the belt is fastened or the key is turned off.

The block's outputs are a timer-start pulse, alarm-on and alarm-off pulses, and a level alarm output that follows those pulses. Any input that is not asserted counts as absent. In any case not listed below, the state does not change.

Top module: `belt_reminder_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, every output is low and the controller is idle.
- R2: A `key_on_i` pulse while idle produces a one-cycle `start_o` in the next cycle, enters waiting, and restarts the seconds count at zero.
- R3: While waiting, a `key_off_i` or `belt_i` pulse returns the controller to idle. `alarm_on_o` and `alarm_o` stay low.
- R4: The count increments on each `tick_i` sampled while waiting or alarming, but not in the cycle of the key-on. The tick that brings the count to SHORT_SECS (default 5) raises the short mark in the next cycle. If the controller is still waiting at that point, `alarm_on_o` pulses and `alarm_o` rises one cycle after the mark.
- R5: While alarming, a `belt_i` pulse, a `key_off_i` pulse or the LONG_SECS mark (default 10, counted from the same start) causes a one-cycle `alarm_off_o` in the next cycle and a return to idle.
- R6: While waiting, `key_off_i` or `belt_i` in the same cycle as the short mark wins, and no alarm is raised.
- R7: `alarm_o` is high exactly while alarming. It rises together with `alarm_on_o` and falls together with `alarm_off_o`.
- R8: A `key_on_i` pulse while waiting or alarming has no effect. There is no `start_o` and no restart of the count.
- R9: Ticks before any start, and ticks after the LONG_SECS mark, produce no mark. Once stopped, the count stays stopped until the next start.
- R10: `start_o`, `alarm_on_o` and `alarm_off_o` are one-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second enable pulse |
| key_on_i | input | 1 | Key turned on (event pulse) |
| key_off_i | input | 1 | Key turned off (event pulse) |
| belt_i | input | 1 | Belt fastened (event pulse) |
| start_o | output | 1 | Timer started (pulse) |
| alarm_on_o | output | 1 | Alarm raised (pulse) |
| alarm_off_o | output | 1 | Alarm cleared (pulse) |
| alarm_o | output | 1 | Alarm level |

## Verification
The bench keeps the default marks of 5 and 10 seconds, so both timer thresholds and the full alarm run are covered with the real values. `tick_i` is driven both as a sparse enable and as an enable that is high on every cycle. The sparse pattern separates tick counting from the clock. The dense pattern puts a tick in the key-on cycle, so the bench can show that this tick is not counted. Events are placed on the exact cycle of the short mark, which exercises the priority rule, and ticks run on after the long mark to show the count has stopped.

// File: rtl/belt_reminder_pkg.sv
`timescale 1ns/1ps
package belt_reminder_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALARM = 2'd2
  } br_state_e;
endpackage

// File: rtl/br_sec_timer.sv
`timescale 1ns/1ps
module br_sec_timer #(
  parameter int SHORT_SECS = 5,
  parameter int LONG_SECS  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic short_o,
  output logic long_o
);
  localparam int CNT_W = $clog2(LONG_SECS + 1);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_SECS);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_SECS);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      short_o <= 1'b0;
      long_o  <= 1'b0;
    end else begin
      short_o <= 1'b0;
      long_o  <= 1'b0;
      if (start_i) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == SHORT_CNT) short_o <= 1'b1;
        if (cnt_inc == LONG_CNT) begin
          long_o <= 1'b1;
          run_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/br_ctrl_fsm.sv
`timescale 1ns/1ps
module br_ctrl_fsm
  import belt_reminder_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_on_i,
  input  logic key_off_i,
  input  logic belt_i,
  input  logic short_i,
  input  logic long_i,
  output logic start_req_o,
  output logic start_o,
  output logic alarm_on_o,
  output logic alarm_off_o,
  output logic alarm_o
);
  br_state_e state_q, state_d;
  logic      on_d, off_d;

  always_comb begin
    state_d     = state_q;
    start_req_o = 1'b0;
    on_d        = 1'b0;
    off_d       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (key_on_i) begin
        start_req_o = 1'b1;
        state_d     = ST_WAIT;
      end
      ST_WAIT: begin
        // cancel wins over the short mark
        if (key_off_i || belt_i) begin
          state_d = ST_IDLE;
        end else if (short_i) begin
          on_d    = 1'b1;
          state_d = ST_ALARM;
        end
      end
      ST_ALARM: if (long_i || belt_i || key_off_i) begin
        off_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      start_o     <= 1'b0;
      alarm_on_o  <= 1'b0;
      alarm_off_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_o     <= start_req_o;
      alarm_on_o  <= on_d;
      alarm_off_o <= off_d;
    end
  end

  assign alarm_o = (state_q == ST_ALARM);
endmodule

// File: rtl/belt_reminder_ctrl.sv
`timescale 1ns/1ps
module belt_reminder_ctrl #(
  parameter int SHORT_SECS = 5,
  parameter int LONG_SECS  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_on_i,
  input  logic key_off_i,
  input  logic belt_i,
  output logic start_o,
  output logic alarm_on_o,
  output logic alarm_off_o,
  output logic alarm_o
);
  logic start_req, short_evt, long_evt;

  br_sec_timer #(
    .SHORT_SECS(SHORT_SECS),
    .LONG_SECS (LONG_SECS)
  ) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_req),
    .tick_i (tick_i),
    .short_o(short_evt),
    .long_o (long_evt)
  );

  br_ctrl_fsm fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_on_i   (key_on_i),
    .key_off_i  (key_off_i),
    .belt_i     (belt_i),
    .short_i    (short_evt),
    .long_i     (long_evt),
    .start_req_o(start_req),
    .start_o    (start_o),
    .alarm_on_o (alarm_on_o),
    .alarm_off_o(alarm_off_o),
    .alarm_o    (alarm_o)
  );
endmodule

// File: rtl/belt_reminder_chk.sv
`timescale 1ns/1ps
module belt_reminder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic key_on_i,
  input logic key_off_i,
  input logic belt_i,
  input logic start_o,
  input logic alarm_on_o,
  input logic alarm_off_o,
  input logic alarm_o
);
  // R10
  pulses_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, alarm_on_o, alarm_off_o}));
  // R2
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(key_on_i) && !alarm_o);
  // R7
  alarm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> alarm_on_o);
  // R7
  alarm_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> alarm_off_o);
  // R5
  alarm_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && (belt_i || key_off_i) |=> alarm_off_o && !alarm_o);
  // R8
  key_on_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && key_on_i |=> !start_o);
  // R10
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind belt_reminder_ctrl belt_reminder_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_on_i   (key_on_i),
  .key_off_i  (key_off_i),
  .belt_i     (belt_i),
  .start_o    (start_o),
  .alarm_on_o (alarm_on_o),
  .alarm_off_o(alarm_off_o),
  .alarm_o    (alarm_o)
);

// File: tb/belt_reminder_ctrl_tb_top.sv
`timescale 1ns/1ps
module belt_reminder_ctrl_tb_top;
  localparam int SHORT = 5;
  localparam int LONG  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, kon = 1'b0, koff = 1'b0, belt = 1'b0;
  logic start_w, on_w, off_w, alarm_w;
  int   n_chk = 0, n_fail = 0, n_cyc = 0;

  always #2 clk = ~clk;

  belt_reminder_ctrl #(.SHORT_SECS(SHORT), .LONG_SECS(LONG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .key_on_i(kon),
    .key_off_i(koff), .belt_i(belt), .start_o(start_w),
    .alarm_on_o(on_w), .alarm_off_o(off_w), .alarm_o(alarm_w));

  // behavioural reference: 0 idle, 1 waiting, 2 alarming
  int m_st, m_secs;
  bit m_run, m_short, m_long, m_start, m_on, m_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_secs = 0; m_run = 0; m_short = 0; m_long = 0;
      m_start = 0; m_on = 0; m_off = 0;
    end else begin
      bit restart;
      restart = 0; m_start = 0; m_on = 0; m_off = 0;
      if (m_st == 0) begin
        if (kon) begin restart = 1; m_start = 1; m_st = 1; end
      end else if (m_st == 1) begin
        if (koff || belt) m_st = 0;
        else if (m_short) begin m_on = 1; m_st = 2; end
      end else begin
        if (m_long || belt || koff) begin m_off = 1; m_st = 0; end
      end
      m_short = 0; m_long = 0;
      if (restart) begin
        m_secs = 0; m_run = 1;
      end else if (m_run && tick) begin
        m_secs++;
        if (m_secs == SHORT) m_short = 1;
        if (m_secs == LONG) begin m_long = 1; m_run = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(start_w == m_start, "R2 start_o", start_w, m_start);
    check(on_w == m_on, "R4 alarm_on_o", on_w, m_on);
    check(off_w == m_off, "R5 alarm_off_o", off_w, m_off);
    check(alarm_w == (m_st == 2), "R7 alarm_o", alarm_w, m_st == 2);
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 20000);
      summary();
    end
  end

  // one cycle of stimulus: {tick, key_on, key_off, belt}
  task automatic cyc(input bit t, input bit on, input bit off, input bit b);
    tick = t; kon = on; koff = off; belt = b;
    @(negedge clk);
    tick = 0; kon = 0; koff = 0; belt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0);
      idle(gap);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1
    check({start_w, on_w, off_w, alarm_w} == 4'b0, "R1 in reset", alarm_w, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({start_w, on_w, off_w, alarm_w} == 4'b0, "R1 after release", alarm_w, 0);

    // R9: ticks and cancels while idle change nothing
    ticks(12, 1);
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 1);
    check(alarm_w == 0 && start_w == 0, "R9 idle ticks", alarm_w, 0);

    // R3: belt cancels while waiting
    cyc(0, 1, 0, 0);
    check(start_w == 1, "R2 start pulse", start_w, 1);
    ticks(2, 2);
    cyc(0, 0, 0, 1);
    ticks(6, 0); idle(2);
    check(alarm_w == 0, "R3 belt cancel", alarm_w, 0);

    // R3: key-off cancels while waiting
    cyc(0, 1, 0, 0);
    ticks(4, 1);
    cyc(0, 0, 1, 0);
    ticks(6, 0); idle(2);
    check(alarm_w == 0, "R3 key-off cancel", alarm_w, 0);

    // R4, R5: full alarm run ended by the long mark
    cyc(0, 1, 0, 0);
    ticks(4, 3);
    cyc(1, 0, 0, 0);
    idle(1);
    check(alarm_w == 1 && on_w == 1, "R4 alarm raised", alarm_w, 1);
    ticks(4, 2);
    cyc(1, 0, 0, 0);
    idle(1);
    check(off_w == 1 && alarm_w == 0, "R5 long mark clear", off_w, 1);
    // R9: count stopped after the long mark
    ticks(12, 0); idle(2);
    check(alarm_w == 0 && on_w == 0, "R9 stopped after long", alarm_w, 0);

    // R5: belt ends alarm early
    cyc(0, 1, 0, 0);
    ticks(SHORT, 0); idle(2);
    cyc(0, 0, 0, 1);
    check(off_w == 1 && alarm_w == 0, "R5 belt clear", off_w, 1);

    // R5: key-off ends alarm early
    cyc(0, 1, 0, 0);
    ticks(SHORT, 1); idle(1);
    cyc(0, 0, 1, 0);
    check(off_w == 1 && alarm_w == 0, "R5 key-off clear", off_w, 1);

    // R8: second key-on while waiting does not restart
    cyc(0, 1, 0, 0);
    ticks(3, 0);
    cyc(0, 1, 0, 0);
    check(start_w == 0, "R8 no restart pulse", start_w, 0);
    ticks(2, 0);
    idle(1);
    check(alarm_w == 1, "R8 count kept", alarm_w, 1);
    cyc(0, 1, 0, 0);
    check(start_w == 0 && alarm_w == 1, "R8 key-on in alarm", start_w, 0);
    cyc(0, 0, 0, 1);

    // R6: cancel on the cycle of the short mark wins
    cyc(0, 1, 0, 0);
    ticks(SHORT, 0);
    cyc(0, 0, 0, 1);
    check(alarm_w == 0 && on_w == 0, "R6 belt over short", alarm_w, 0);
    cyc(0, 1, 0, 0);
    ticks(SHORT, 0);
    cyc(0, 0, 1, 0);
    check(alarm_w == 0 && on_w == 0, "R6 key-off over short", alarm_w, 0);

    // R2, R4: dense ticks, key-on cycle tick not counted
    cyc(1, 1, 0, 0);
    ticks(SHORT - 1, 0);
    cyc(1, 0, 0, 0);
    check(alarm_w == 0, "R4 no early alarm", alarm_w, 0);
    cyc(1, 0, 0, 0);
    check(alarm_w == 1 && on_w == 1, "R4 dense alarm", alarm_w, 1);
    ticks(LONG - SHORT, 0);
    idle(1);
    check(alarm_w == 0, "R5 dense clear", alarm_w, 0);
    idle(3);
    summary();
  end
endmodule